// File: doc/BRIEF.md
# Store-to-Load Forwarding Queue

This block keeps a small circular queue of in-flight stores and answers byte-level forwarding questions from a two-stage load pipeline. Stores are allocated at the tail pointer and released at the head pointer. Each pointer carries one extra wrap bit, so a full queue can be told apart from an empty one. The address half of a store and the data half of a store arrive on separate ports. Each entry has its own address-valid and data-valid flag.

A load enters stage 1 with its virtual address, its byte enables and a mask of the queue entries that are older than it. The load pipeline builds that mask a stage earlier from the tail pointer it recorded. Stage 1 returns a quick per-byte hit vector and a quick "data not ready" flag. Both are computed by virtual-address match. In stage 2 the physical address arrives. The block then returns the forwarded bytes and their hit mask, a "data not ready" flag with the index of the store to wait on, and a flag that is raised when virtual and physical matching pick different sets of stores.

Top module: `stld_fwd_queue`

## Requirements
- R1: After reset both pointers read zero, and no entry is allocated, address-valid or data-valid.
- R2: Each allocate advances `tail_ptr` and each free advances `head_ptr` by one. Each pointer has 1+log2(ENTRIES) bits. The top bit flips on every wrap of the index bits. The entry index is the low log2(ENTRIES) bits.
- R3: A store address write requested in cycle t becomes visible to loads from cycle t+2. A store data write requested in cycle t is visible from cycle t+1.
- R4: Stage 1 sets `ld1_fast_hit[b]` when the load enables byte b and some eligible entry matches on virtual address bits [VA_W-1:3] and has byte b in its store mask. An entry is eligible when it is marked older, allocated and address-valid.
- R5: For each byte, stage 2 picks the youngest eligible entry whose physical address bits [PA_W-1:3] match and whose store mask has that byte. Age is counted from `head_ptr`. If that entry is data-valid, `ld2_hit[b]` is 1 and byte b of `ld2_data` (bits 8b+7..8b) is that entry's byte b. Otherwise `ld2_hit[b]` is 0 and the byte reads zero.
- R6: Entries whose `ld1_older` bit is 0 never forward, even when their addresses match.
- R7: `ld1_fast_wait` is raised when a byte's youngest virtual-match entry lacks data. `ld2_wait` is raised when a byte's youngest physical-match entry lacks data. `ld2_wait_idx` then gives the youngest such entry.
- R8: `ld2_addr_conflict` is raised when the eligible entries that match by virtual tag differ from those that match by physical tag. Only entries whose store mask overlaps the load mask count.
- R9: Allocating into a full queue is illegal. The occupancy never exceeds ENTRIES.
- R10: The cycle after a stage-1 slot with `ld1_valid` low, all stage-2 outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| alloc_en | input | 1 | allocate the entry at the tail |
| free_en | input | 1 | release the entry at the head |
| tail_ptr | output | IW+1 | allocation pointer with wrap bit |
| head_ptr | output | IW+1 | release pointer with wrap bit |
| st_addr_en | input | 1 | store address write request |
| st_addr_idx | input | IW | entry receiving the address |
| st_vaddr | input | VA_W | store virtual address |
| st_paddr | input | PA_W | store physical address |
| st_bmask | input | 8 | store byte mask |
| st_data_en | input | 1 | store data write request |
| st_data_idx | input | IW | entry receiving the data |
| st_data | input | 64 | store data doubleword |
| ld1_valid | input | 1 | load present in stage 1 |
| ld1_vaddr | input | VA_W | load virtual address |
| ld1_bmask | input | 8 | load byte enables |
| ld1_older | input | ENTRIES | entries older than the load |
| ld1_fast_hit | output | 8 | quick per-byte hit |
| ld1_fast_wait | output | 1 | quick data-not-ready |
| ld2_paddr | input | PA_W | load physical address, stage 2 |
| ld2_hit | output | 8 | forwarded byte mask |
| ld2_data | output | 64 | forwarded bytes |
| ld2_wait | output | 1 | data not ready, replay needed |
| ld2_wait_idx | output | IW | entry to wait on |
| ld2_addr_conflict | output | 1 | virtual and physical matches disagree |

## Verification
The bench builds the queue with 4 entries and 6-bit addresses. That leaves three tag bits, and the bench draws tags from only four values. Address collisions among stores are therefore common, and several older stores often cover the same byte, which exercises youngest-wins selection. With 4 entries the pointers wrap every few iterations, so age ordering across the wrap boundary is covered as well. Occasional mismatched physical tags drive the conflict flag both ways.

// File: rtl/stld_fwd_queue.sv
module stld_fwd_queue #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 39,
  parameter int PA_W    = 36,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_en,
  input  logic               free_en,
  output logic [IW:0]        tail_ptr,
  output logic [IW:0]        head_ptr,
  input  logic               st_addr_en,
  input  logic [IW-1:0]      st_addr_idx,
  input  logic [VA_W-1:0]    st_vaddr,
  input  logic [PA_W-1:0]    st_paddr,
  input  logic [7:0]         st_bmask,
  input  logic               st_data_en,
  input  logic [IW-1:0]      st_data_idx,
  input  logic [63:0]        st_data,
  input  logic               ld1_valid,
  input  logic [VA_W-1:0]    ld1_vaddr,
  input  logic [7:0]         ld1_bmask,
  input  logic [ENTRIES-1:0] ld1_older,
  output logic [7:0]         ld1_fast_hit,
  output logic               ld1_fast_wait,
  input  logic [PA_W-1:0]    ld2_paddr,
  output logic [7:0]         ld2_hit,
  output logic [63:0]        ld2_data,
  output logic               ld2_wait,
  output logic [IW-1:0]      ld2_wait_idx,
  output logic               ld2_addr_conflict
);
  // ENTRIES must be a power of two: the wrap bit sits just above the index bits.
  logic [ENTRIES-1:0] alloc, av, dv;
  logic [VA_W-4:0]    e_vtag [ENTRIES];
  logic [PA_W-4:0]    e_ptag [ENTRIES];
  logic [7:0]         e_bm   [ENTRIES];
  logic [63:0]        e_dat  [ENTRIES];

  logic               pend;
  logic [IW-1:0]      pend_idx;
  logic [VA_W-4:0]    pend_vtag;
  logic [PA_W-4:0]    pend_ptag;
  logic [7:0]         pend_bm;

  logic               ld2_v;
  logic [VA_W-4:0]    ld2_vtag;
  logic [7:0]         ld2_bm;
  logic [ENTRIES-1:0] ld2_older;

  logic [IW-1:0] hidx;
  assign hidx = head_ptr[IW-1:0];

  logic unused_low;
  assign unused_low = ^{st_vaddr[2:0], st_paddr[2:0], ld1_vaddr[2:0], ld2_paddr[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_ptr <= '0;
      head_ptr <= '0;
      alloc    <= '0;
      av       <= '0;
      dv       <= '0;
      pend     <= 1'b0;
      ld2_v    <= 1'b0;
    end else begin
      if (alloc_en) begin
        alloc[tail_ptr[IW-1:0]] <= 1'b1;
        av[tail_ptr[IW-1:0]]    <= 1'b0;
        dv[tail_ptr[IW-1:0]]    <= 1'b0;
        tail_ptr                <= tail_ptr + 1'b1;
      end
      if (free_en) begin
        alloc[hidx] <= 1'b0;
        head_ptr    <= head_ptr + 1'b1;
      end
      pend <= st_addr_en;
      if (pend) av[pend_idx] <= 1'b1;
      if (st_data_en) dv[st_data_idx] <= 1'b1;
      ld2_v <= ld1_valid;
    end
  end

  always_ff @(posedge clk) begin
    pend_idx  <= st_addr_idx;
    pend_vtag <= st_vaddr[VA_W-1:3];
    pend_ptag <= st_paddr[PA_W-1:3];
    pend_bm   <= st_bmask;
    if (pend) begin
      e_vtag[pend_idx] <= pend_vtag;
      e_ptag[pend_idx] <= pend_ptag;
      e_bm[pend_idx]   <= pend_bm;
    end
    if (st_data_en) e_dat[st_data_idx] <= st_data;
    ld2_vtag  <= ld1_vaddr[VA_W-1:3];
    ld2_bm    <= ld1_bmask;
    ld2_older <= ld1_older;
  end

  logic [ENTRIES-1:0] vm1, vm2, pm2;
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      vm1[i] = ld1_older[i] && alloc[i] && av[i] && (e_vtag[i] == ld1_vaddr[VA_W-1:3])
               && |(e_bm[i] & ld1_bmask);
      vm2[i] = ld2_older[i] && alloc[i] && av[i] && (e_vtag[i] == ld2_vtag)
               && |(e_bm[i] & ld2_bm);
      pm2[i] = ld2_older[i] && alloc[i] && av[i] && (e_ptag[i] == ld2_paddr[PA_W-1:3])
               && |(e_bm[i] & ld2_bm);
    end
  end

  logic [7:0]    h1, h2;
  logic [IW-1:0] sel1 [8];
  logic [IW-1:0] sel2 [8];
  always_comb begin
    logic [IW-1:0] idx;
    for (int b = 0; b < 8; b++) begin
      h1[b] = 1'b0; sel1[b] = '0;
      h2[b] = 1'b0; sel2[b] = '0;
      for (int k = 0; k < ENTRIES; k++) begin
        idx = hidx + IW'(k);
        if (vm1[idx] && e_bm[idx][b] && ld1_bmask[b]) begin h1[b] = 1'b1; sel1[b] = idx; end
        if (pm2[idx] && e_bm[idx][b] && ld2_bm[b])    begin h2[b] = 1'b1; sel2[b] = idx; end
      end
    end
  end

  always_comb begin
    logic          found;
    logic [IW-1:0] best, age;
    ld1_fast_hit  = ld1_valid ? h1 : 8'h00;
    ld1_fast_wait = 1'b0;
    found = 1'b0; best = '0; age = '0; ld2_wait_idx = '0;
    for (int b = 0; b < 8; b++) begin
      if (ld1_valid && h1[b] && !dv[sel1[b]]) ld1_fast_wait = 1'b1;
      ld2_hit[b]          = ld2_v && h2[b] && dv[sel2[b]];
      ld2_data[8*b +: 8]  = ld2_hit[b] ? e_dat[sel2[b]][8*b +: 8] : 8'h00;
      if (ld2_v && h2[b] && !dv[sel2[b]]) begin
        age = sel2[b] - hidx;
        if (!found || age >= best) begin
          found = 1'b1; best = age; ld2_wait_idx = sel2[b];
        end
      end
    end
    ld2_wait          = found;
    ld2_addr_conflict = ld2_v && (vm2 != pm2);
  end

  logic [IW:0] occ;
  assign occ = tail_ptr - head_ptr;

  assert_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (IW+1)'(ENTRIES));
  assert_hit_inside_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld2_hit & ~ld2_bm) == 8'h00);
  assert_wait_points_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld2_wait |-> (!dv[ld2_wait_idx] && alloc[ld2_wait_idx]));
  assert_idle_stage2_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld2_v |-> (ld2_hit == 8'h00 && !ld2_wait && !ld2_addr_conflict));
  assert_hit_needs_older_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld1_fast_hit != 8'h00) |-> ((ld1_older & alloc) != '0));
endmodule

// File: tb/stld_fwd_queue_tb.sv
module stld_fwd_queue_tb;
  localparam int N = 4, VW = 6, PW = 6, IW = 2;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic alloc_en = 0, free_en = 0, st_addr_en = 0, st_data_en = 0, ld1_valid = 0;
  logic [IW:0] tail_ptr, head_ptr;
  logic [IW-1:0] st_addr_idx = 0, st_data_idx = 0, ld2_wait_idx;
  logic [VW-1:0] st_vaddr = 0, ld1_vaddr = 0;
  logic [PW-1:0] st_paddr = 0, ld2_paddr = 0;
  logic [7:0] st_bmask = 0, ld1_bmask = 0, ld1_fast_hit, ld2_hit;
  logic [63:0] st_data = 0, ld2_data;
  logic [N-1:0] ld1_older = 0;
  logic ld1_fast_wait, ld2_wait, ld2_addr_conflict;

  stld_fwd_queue #(.ENTRIES(N), .VA_W(VW), .PA_W(PW)) u_dut (.*);

  int total = 0, bad = 0;
  int m_head = 0, m_tail = 0;
  bit m_alloc [N], m_av [N], m_dv [N];
  int m_vt [N], m_pt [N];
  logic [7:0] m_bm [N];
  logic [63:0] m_dat [N];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int occ();
    return (m_tail - m_head + 2*N) % (2*N);
  endfunction

  task automatic do_enq();
    alloc_en = 1; @(negedge clk); alloc_en = 0;
    m_alloc[m_tail % N] = 1; m_av[m_tail % N] = 0; m_dv[m_tail % N] = 0;
    m_tail = (m_tail + 1) % (2*N);
  endtask

  task automatic do_deq();
    free_en = 1; @(negedge clk); free_en = 0;
    m_alloc[m_head % N] = 0;
    m_head = (m_head + 1) % (2*N);
  endtask

  task automatic do_addr(int idx, int vt, int pt, logic [7:0] bm);
    st_addr_en = 1; st_addr_idx = IW'(idx);
    st_vaddr = VW'(vt * 8 + $urandom_range(0, 7));
    st_paddr = PW'(pt * 8 + $urandom_range(0, 7));
    st_bmask = bm;
    @(negedge clk); st_addr_en = 0; @(negedge clk);
    m_av[idx] = 1; m_vt[idx] = vt; m_pt[idx] = pt; m_bm[idx] = bm;
  endtask

  task automatic do_data(int idx, logic [63:0] d);
    st_data_en = 1; st_data_idx = IW'(idx); st_data = d;
    @(negedge clk); st_data_en = 0;
    m_dv[idx] = 1; m_dat[idx] = d;
  endtask

  // Reference: scan older entries oldest first, last match wins.
  task automatic query(logic [N-1:0] older, int vt, int pt, logic [7:0] bm);
    logic [7:0] e1, e2h; logic [63:0] e2d; bit w1, w2; int widx, wage;
    logic [N-1:0] vm, pm;
    ld1_valid = 1; ld1_older = older; ld1_bmask = bm;
    ld1_vaddr = VW'(vt * 8 + $urandom_range(0, 7));
    e1 = 0; e2h = 0; e2d = 0; w1 = 0; w2 = 0; widx = 0; wage = -1;
    for (int i = 0; i < N; i++) begin
      bit el = older[i] && m_alloc[i] && m_av[i] && ((m_bm[i] & bm) != 0);
      vm[i] = el && m_vt[i] == vt;
      pm[i] = el && m_pt[i] == pt;
    end
    for (int b = 0; b < 8; b++) begin
      int s1 = -1, s2 = -1, a2 = 0;
      for (int k = 0; k < N; k++) begin
        int idx = (m_head + k) % N;
        if (vm[idx] && m_bm[idx][b] && bm[b]) s1 = idx;
        if (pm[idx] && m_bm[idx][b] && bm[b]) begin s2 = idx; a2 = k; end
      end
      if (s1 >= 0) begin e1[b] = 1; if (!m_dv[s1]) w1 = 1; end
      if (s2 >= 0) begin
        if (m_dv[s2]) begin e2h[b] = 1; e2d[8*b +: 8] = m_dat[s2][8*b +: 8]; end
        else begin w2 = 1; if (a2 >= wage) begin wage = a2; widx = s2; end end
      end
    end
    #1;
    chk("R4 stage1 fast hit", ld1_fast_hit, e1);
    chk("R7 stage1 fast wait", ld1_fast_wait, w1);
    @(negedge clk);
    ld1_valid = 0; ld2_paddr = PW'(pt * 8 + $urandom_range(0, 7));
    #1;
    chk("R5 stage2 hit mask", ld2_hit, e2h);
    chk("R5 R6 stage2 data", ld2_data, e2d);
    chk("R7 stage2 wait", ld2_wait, w2);
    if (w2) chk("R7 stage2 wait index", ld2_wait_idx, widx);
    chk("R8 addr conflict", ld2_addr_conflict, vm != pm);
    @(negedge clk); #1;
    chk("R10 idle stage2", {ld2_hit, ld2_wait, ld2_addr_conflict}, 0);
  endtask

  bit done = 0;
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_alloc[i] = 0; m_av[i] = 0; m_dv[i] = 0; m_bm[i] = 0; m_dat[i] = 0; m_vt[i] = 0; m_pt[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 reset pointers", {tail_ptr, head_ptr}, 0);
    chk("R1 reset outputs", {ld1_fast_hit, ld2_hit, ld2_wait}, 0);

    // R3 timing of address (two cycles) and data (one cycle)
    do_enq();
    st_addr_en = 1; st_addr_idx = 0; st_vaddr = 6'd17; st_paddr = 6'd17; st_bmask = 8'h3C;
    ld1_valid = 1; ld1_older = 4'b0001; ld1_vaddr = 6'd16; ld1_bmask = 8'hFF;
    @(negedge clk); st_addr_en = 0; #1;
    chk("R3 address not yet visible", ld1_fast_hit, 8'h00);
    @(negedge clk); #1;
    chk("R3 address visible", ld1_fast_hit, 8'h3C);
    chk("R7 fast wait before data", ld1_fast_wait, 1);
    ld1_older = 4'b0000; #1;
    chk("R6 not older, no hit", ld1_fast_hit, 8'h00);
    ld1_older = 4'b0001;
    st_data_en = 1; st_data_idx = 0; st_data = 64'h1122334455667788;
    @(negedge clk); st_data_en = 0; #1;
    chk("R3 data visible next cycle", ld1_fast_wait, 0);
    ld1_valid = 0;
    @(negedge clk);
    m_av[0] = 1; m_dv[0] = 1; m_vt[0] = 2; m_pt[0] = 2; m_bm[0] = 8'h3C; m_dat[0] = 64'h1122334455667788;

    for (int it = 0; it < 400; it++) begin
      int nd = $urandom_range(0, occ());
      for (int j = 0; j < nd; j++) do_deq();
      begin
        int ne = $urandom_range(0, N - occ());
        for (int j = 0; j < ne; j++) do_enq();
      end
      chk("R2 tail pointer", tail_ptr, m_tail);
      chk("R2 head pointer", head_ptr, m_head);
      for (int k = 0; k < occ(); k++) begin
        int idx = (m_head + k) % N;
        if ($urandom_range(0, 3) != 0) begin
          int vt = $urandom_range(0, 3);
          int pt = ($urandom_range(0, 7) == 0) ? $urandom_range(4, 7) : vt;
          logic [7:0] bm = 8'($urandom_range(1, 255));
          do_addr(idx, vt, pt, bm);
        end
        if ($urandom_range(0, 2) != 0) do_data(idx, {$urandom, $urandom});
      end
      begin
        int kk = $urandom_range(0, occ());
        logic [N-1:0] older = 0;
        int vt = $urandom_range(0, 3);
        int pt = ($urandom_range(0, 7) == 0) ? $urandom_range(4, 7) : vt;
        for (int k = 0; k < kk; k++) older[(m_head + k) % N] = 1;
        query(older, vt, pt, 8'($urandom_range(0, 255)));
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule